// File: doc/BRIEF.md
# Two-Wire Serial Slave with Page-Buffered Writes

This block is a two-wire serial slave placed in front of a 256-location byte memory. It runs on a fast system clock and oversamples the serial clock and data lines. It detects start and stop conditions and answers one device address, which an input pin selects. It supports single-byte writes, 8-byte page writes, current-address reads, random reads and sequential reads. The data line is open drain, so the block has no tristate. It reads the line level on one input and gives out one enable, and the line is pulled low while that enable is high.

Incoming write data lands in a page buffer and does not touch the array until the master sends a stop. After the stop, the slave enters a timed write phase that lasts a set number of cycles. In that phase it copies the buffered bytes into the array and acknowledges nothing, so a master can poll until the write completes. The slave's device address is either fixed or taken from a shadow register. That register follows whatever is committed to one configuration location of the array.

Top module: `tws_page_slave`

## Requirements
- R1: A falling data line while the clock is high is a start, and a rising data line while the clock is high is a stop. Clock pulses that arrive after a stop and before the next start are ignored, and the slave never drives the line for them.
- R2: The 7-bit device address is compared with bits 7:1 of the first byte after a start, and bit 0 of that byte is 1 for read. With addrSel low the address byte is A0h. With addrSel high the address comes from a shadow register that resets to A2h and takes the value committed to location D0h. A byte that does not match gets no acknowledge.
- R3: Bytes are shifted in MSB first on rising clock edges. The slave acknowledges each byte by pulling the line low through the ninth clock period.
- R4: A write is a word address byte followed by data bytes. The data reaches the array only if a stop ends the transfer. A repeated start in place of the stop discards the data, and no write phase follows.
- R5: Within a write the address steps through an aligned 8-byte page and wraps to the page start, so 06h, 07h is followed by 00h, 01h.
- R6: If more than 8 data bytes are sent before the stop, later bytes replace earlier ones in the same page slot. Only the last 8 bytes are stored.
- R7: From a committing stop until WRITE_CYCLES system cycles have passed, the slave acknowledges no address byte. After that it acknowledges again.
- R8: A random read sends a write-mode address and a word address, then a repeated start with a read-mode address. It returns the byte at that word address.
- R9: Each byte read advances the address by one across the whole space, wrapping from FFh to 00h. A current-address read continues from one past the last byte accessed.
- R10: A master NACK after a read byte ends the transfer, and the slave leaves the line released until the next start.
- R11: Read data and acknowledge bits change only while the clock is low, so the data line is stable whenever the clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | Pulls the data line low when high |
| addrSel | input | 1 | 0: fixed device address A0h; 1: address from the shadow register |

## Verification
A wrong address pointer shows up in the first data byte of the next read, and a missing page wrap shows up as a wrong byte at a page start. A busy flag stuck high, or cleared too early, shows up in the acknowledge bit of the very next address byte. A buffer that is not cleared on a repeated start appears only after a later read of that location. The bench therefore reads back every write, polls right after each stop, and checks the line level on every ninth clock.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic shiftIn;
    logic rxBit;
    logic loadAddr;
    logic bufWrite;
    logic loadTx;
    logic shiftTx;
    logic startSeen;
    logic stopSeen;
  } twsStrobeT;
endpackage

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  input  logic              busy,
  input  logic [6:0]        devAddr,
  output twsStrobeT         strb,
  output logic              sdaOe
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADR, ST_WADR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
  } stateT;

  stateT state, stateNx;
  logic [3:0] bitCnt, bitCntNx;
  logic ackDrive, ackDriveNx;
  logic rdMode, rdModeNx;
  logic mAck, mAckNx;
  logic [1:0] sclSync, sdaSync;
  logic sclP, sdaP;
  logic sclNow, sdaNow, sclRise, sclFall, startCond, stopCond;

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclP;
  assign sclFall   = ~sclNow & sclP;
  assign startCond = sclNow & sclP & sdaP & ~sdaNow;
  assign stopCond  = sclNow & sclP & ~sdaP & sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync  <= 2'b11;
      sdaSync  <= 2'b11;
      sclP     <= 1'b1;
      sdaP     <= 1'b1;
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      rdMode   <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      sclSync  <= {sclSync[0], scl};
      sdaSync  <= {sdaSync[0], sdaIn};
      sclP     <= sclNow;
      sdaP     <= sdaNow;
      state    <= stateNx;
      bitCnt   <= bitCntNx;
      ackDrive <= ackDriveNx;
      rdMode   <= rdModeNx;
      mAck     <= mAckNx;
    end
  end

  always_comb begin
    stateNx    = state;
    bitCntNx   = bitCnt;
    ackDriveNx = ackDrive;
    rdModeNx   = rdMode;
    mAckNx     = mAck;
    strb       = '0;
    if (startCond) begin
      stateNx        = ST_DEV;
      bitCntNx       = '0;
      ackDriveNx     = 1'b0;
      strb.startSeen = 1'b1;
    end else if (stopCond) begin
      stateNx       = ST_IDLE;
      ackDriveNx    = 1'b0;
      strb.stopSeen = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            strb.rxBit   = sdaNow;
            bitCntNx     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntNx = '0;
            if (state == ST_DEV) begin
              if (rxByte[7:1] == devAddr && !busy) begin
                stateNx    = ST_DEV_ACK;
                ackDriveNx = 1'b1;
                rdModeNx   = rxByte[0];
              end else begin
                stateNx = ST_IDLE;
              end
            end else if (state == ST_WADR) begin
              stateNx       = ST_WADR_ACK;
              ackDriveNx    = 1'b1;
              strb.loadAddr = 1'b1;
            end else begin
              stateNx       = ST_WDAT_ACK;
              ackDriveNx    = 1'b1;
              strb.bufWrite = 1'b1;
            end
          end
        end
        ST_DEV_ACK: begin
          if (sclFall) begin
            ackDriveNx = 1'b0;
            if (rdMode) begin
              strb.loadTx = 1'b1;
              stateNx     = ST_RDAT;
              bitCntNx    = '0;
            end else begin
              stateNx = ST_WADR;
            end
          end
        end
        ST_WADR_ACK, ST_WDAT_ACK: begin
          if (sclFall) begin
            ackDriveNx = 1'b0;
            stateNx    = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateNx  = ST_RACK;
              bitCntNx = '0;
            end else begin
              strb.shiftTx = 1'b1;
              bitCntNx     = bitCnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) mAckNx = ~sdaNow;
          if (sclFall) begin
            if (mAck) begin
              strb.loadTx = 1'b1;
              stateNx     = ST_RDAT;
            end else begin
              stateNx = ST_IDLE;
            end
          end
        end
        default: stateNx = ST_IDLE;
      endcase
    end
  end

  assign sdaOe = ((state == ST_RDAT) && !txBit) || ackDrive;

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV_ACK) |-> !busy); // R7
  AST_LINE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclNow && sclP && !startCond && !stopCond) |=> $stable(sdaOe)); // R11
  AST_ACK_AFTER_EIGHT_BITS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> $past(sclFall) && $past(bitCnt) == 4'd8); // R3
endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int                WRITE_CYCLES = 2000,
  parameter int                PAGE_BYTES   = 8,
  parameter logic [DATA_W-1:0] FIXED_DEV    = 8'hA0,
  parameter logic [ADDR_W-1:0] CFG_LOC      = 8'hD0,
  parameter logic [DATA_W-1:0] CFG_RESET    = 8'hA2
)(
  input  logic              clk,
  input  logic              rstN,
  input  twsStrobeT         strb,
  input  logic              addrSel,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit,
  output logic              busy,
  output logic [6:0]        devAddr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int IW    = PW + 1;
  localparam int CW    = $clog2(WRITE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);

  logic [DATA_W-1:0]      rxShift, txShift, rdData, cfgAddr;
  logic [ADDR_W-1:0]      addrPtr;
  logic [DATA_W-1:0]      pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  bufValid;
  logic                   busyR;
  logic [CW-1:0]          busyCnt;
  logic [IW-1:0]          commitIdx;
  logic [ADDR_W-PW-1:0]   commitBase;
  logic [DATA_W-1:0]      mem [DEPTH];
  logic [PW-1:0]          commitSlot, wrSlot;
  logic                   memWe;
  logic [ADDR_W-1:0]      memWAddr;

  assign commitSlot = commitIdx[PW-1:0];
  assign wrSlot     = addrPtr[PW-1:0];
  assign memWe      = busyR && !commitIdx[PW] && bufValid[commitSlot];
  assign memWAddr   = {commitBase, commitSlot};

  always_ff @(posedge clk) begin
    if (memWe) mem[memWAddr] <= pageBuf[commitSlot];
    rdData <= mem[addrPtr];
    if (strb.bufWrite) pageBuf[wrSlot] <= rxShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShift    <= '0;
      addrPtr    <= '0;
      bufValid   <= '0;
      busyR      <= 1'b0;
      busyCnt    <= '0;
      commitIdx  <= '0;
      commitBase <= '0;
      cfgAddr    <= CFG_RESET;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[DATA_W-2:0], strb.rxBit};

      if (strb.loadAddr)      addrPtr <= rxShift;
      else if (strb.bufWrite) addrPtr <= {addrPtr[ADDR_W-1:PW], wrSlot + 1'b1};
      else if (strb.loadTx)   addrPtr <= addrPtr + 1'b1;

      if (strb.loadTx)       txShift <= rdData;
      else if (strb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};

      if (busyR && busyCnt == LAST)      bufValid <= '0;
      else if (strb.startSeen && !busyR) bufValid <= '0;
      else if (strb.bufWrite)            bufValid[wrSlot] <= 1'b1;

      if (!busyR) begin
        if (strb.stopSeen && |bufValid) begin
          busyR      <= 1'b1;
          busyCnt    <= '0;
          commitIdx  <= '0;
          commitBase <= addrPtr[ADDR_W-1:PW];
        end
      end else begin
        busyCnt <= busyCnt + 1'b1;
        if (busyCnt == LAST) busyR <= 1'b0;
        if (!commitIdx[PW]) commitIdx <= commitIdx + 1'b1;
      end

      if (memWe && memWAddr == CFG_LOC) cfgAddr <= pageBuf[commitSlot];
    end
  end

  assign rxByte  = rxShift;
  assign txBit   = txShift[DATA_W-1];
  assign busy    = busyR;
  assign devAddr = addrSel ? cfgAddr[7:1] : FIXED_DEV[7:1];

  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWrite |=> addrPtr[ADDR_W-1:PW] == $past(addrPtr[ADDR_W-1:PW])); // R5
  AST_COMMIT_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyR) |-> $past(strb.stopSeen)); // R4
  AST_NO_FILL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyR |-> !strb.bufWrite); // R7
endmodule

// File: rtl/tws_page_slave.sv
module tws_page_slave
  import tws_pkg::*;
#(
  parameter int                WRITE_CYCLES = 2000,
  parameter int                PAGE_BYTES   = 8,
  parameter logic [DATA_W-1:0] FIXED_DEV    = 8'hA0,
  parameter logic [ADDR_W-1:0] CFG_LOC      = 8'hD0,
  parameter logic [DATA_W-1:0] CFG_RESET    = 8'hA2
)(
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic addrSel
);
  twsStrobeT         strb;
  logic [DATA_W-1:0] rxByte;
  logic              txBit;
  logic              busy;
  logic [6:0]        devAddr;

  tws_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .busy(busy), .devAddr(devAddr),
    .strb(strb), .sdaOe(sdaOe)
  );

  tws_datapath #(
    .WRITE_CYCLES(WRITE_CYCLES), .PAGE_BYTES(PAGE_BYTES),
    .FIXED_DEV(FIXED_DEV), .CFG_LOC(CFG_LOC), .CFG_RESET(CFG_RESET)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addrSel(addrSel),
    .rxByte(rxByte), .txBit(txBit), .busy(busy), .devAddr(devAddr)
  );
endmodule

// File: tb/tws_page_slave_tb_top.sv
`timescale 1ns/1ps
module tws_page_slave_tb_top;
  localparam int WR   = 300;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic sdaOe;
  wire  sdaLine = sdaM & ~sdaOe;

  int checks = 0;
  int errors = 0;
  int stableErr = 0;
  bit done = 1'b0;
  int expQ[$];
  int gotQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  tws_page_slave #(.WRITE_CYCLES(WR)) dut_i (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .addrSel(addrSel)
  );

  function automatic void check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (gotQ.size() > 0 && expQ.size() > 0) begin
      int g, e;
      string t;
      g = gotQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(g == e, t, g, e);
    end
  end

  // R11: line stable while scl high
  logic prevScl = 1'b1, prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && scl && prevScl && sdaOe != prevOe) stableErr++;
    prevScl <= scl;
    prevOe  <= sdaOe;
  end

  task automatic halfWait();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1'b1; halfWait();
    scl = 1'b1;  halfWait();
    sdaM = 1'b0; halfWait();
    scl = 1'b0;  halfWait();
  endtask

  task automatic busStop();
    sdaM = 1'b0; halfWait();
    scl = 1'b1;  halfWait();
    sdaM = 1'b1; halfWait();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; halfWait();
      scl = 1'b1;  halfWait();
      scl = 1'b0;  halfWait();
    end
    sdaM = 1'b1; halfWait();
    scl = 1'b1;  halfWait();
    ack = ~sdaLine;
    scl = 1'b0;  halfWait();
  endtask

  task automatic recvByte(input bit ackIt);
    logic [7:0] b;
    b = '0;
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      halfWait();
      scl = 1'b1; halfWait();
      b = {b[6:0], sdaLine};
      scl = 1'b0;
    end
    sdaM = ~ackIt; halfWait();
    scl = 1'b1;    halfWait();
    scl = 1'b0;    halfWait();
    sdaM = 1'b1;
    gotQ.push_back(int'(b));
  endtask

  task automatic expectByte(input int v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic writeBytes(input logic [7:0] dev, input logic [7:0] wa,
                            input logic [7:0] data[$], input bit endStop);
    logic a;
    busStart();
    sendByte(dev, a);
    check(a, "R2 device ack on write", a, 1);
    sendByte(wa, a);
    check(a, "R3 word address ack", a, 1);
    foreach (data[i]) begin
      sendByte(data[i], a);
      check(a, "R3 data ack", a, 1);
    end
    if (endStop) busStop();
  endtask

  task automatic randomRead(input logic [7:0] dev, input logic [7:0] wa, input int n);
    logic a;
    busStart();
    sendByte(dev, a);
    check(a, "R8 device ack before word address", a, 1);
    sendByte(wa, a);
    busStart();
    sendByte(dev | 8'h01, a);
    check(a, "R8 device ack for read", a, 1);
    for (int i = 0; i < n; i++) recvByte(i != n - 1);
    busStop();
  endtask

  task automatic waitWrite();
    repeat (WR + 100) @(posedge clk);
    #1;
  endtask

  initial begin
    logic a;
    repeat (5) @(posedge clk);
    #1;
    check(sdaOe == 1'b0, "R1 reset releases line", sdaOe, 0);
    rstN = 1'b1;
    halfWait();

    // R1: byte without start ignored
    sendByte(8'hA0, a);
    check(!a, "R1 no ack without start", a, 0);
    busStop();

    // R5: page write wrapping at 06h
    writeBytes(8'hA0, 8'h06, '{8'h11, 8'h22, 8'h33, 8'h44}, 1'b1);
    busStart();
    sendByte(8'hA0, a);
    check(!a, "R7 nack during internal write", a, 0);
    busStop();
    waitWrite();
    expectByte(8'h11, "R8 random read 06h");
    expectByte(8'h22, "R8 random read 07h");
    randomRead(8'hA0, 8'h06, 2);
    check(sdaOe == 1'b0, "R10 line released after nack", sdaOe, 0);
    expectByte(8'h33, "R5 wrapped byte at 00h");
    expectByte(8'h44, "R5 wrapped byte at 01h");
    randomRead(8'hA0, 8'h00, 2);

    // R4: repeated start discards
    writeBytes(8'hA0, 8'h20, '{8'h77}, 1'b1);
    waitWrite();
    writeBytes(8'hA0, 8'h20, '{8'h5A}, 1'b0);
    busStart();
    busStop();
    busStart();
    sendByte(8'hA0, a);
    check(a, "R4 no write phase after aborted write", a, 1);
    busStop();
    expectByte(8'h77, "R4 aborted data not stored");
    randomRead(8'hA0, 8'h20, 1);

    // R6: ten bytes into one page
    writeBytes(8'hA0, 8'h10, '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4,
                                8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC9}, 1'b1);
    waitWrite();
    expectByte(8'hC8, "R6 slot 0 overwritten");
    expectByte(8'hC9, "R6 slot 1 overwritten");
    expectByte(8'hC2, "R6 slot 2 kept");
    expectByte(8'hC3, "R6 slot 3 kept");
    expectByte(8'hC4, "R6 slot 4 kept");
    expectByte(8'hC5, "R6 slot 5 kept");
    randomRead(8'hA0, 8'h10, 6);
    // R9: current-address read
    expectByte(8'hC6, "R9 current address read");
    busStart();
    sendByte(8'hA1, a);
    check(a, "R9 device ack current read", a, 1);
    recvByte(1'b0);
    busStop();

    // R9: wrap FFh -> 00h
    writeBytes(8'hA0, 8'hFF, '{8'hEE}, 1'b1);
    waitWrite();
    expectByte(8'hEE, "R9 byte at FFh");
    expectByte(8'h33, "R9 wrap to 00h");
    randomRead(8'hA0, 8'hFF, 2);

    // R2: selectable address
    addrSel = 1'b1;
    busStart();
    sendByte(8'hA0, a);
    check(!a, "R2 fixed address ignored when select high", a, 0);
    busStop();
    writeBytes(8'hA2, 8'hD0, '{8'hB4}, 1'b1);
    waitWrite();
    busStart();
    sendByte(8'hA2, a);
    check(!a, "R2 old configured address ignored", a, 0);
    busStop();
    expectByte(8'hB4, "R2 read via new address");
    randomRead(8'hB4, 8'hD0, 1);

    repeat (20) @(posedge clk);
    #1;
    check(stableErr == 0, "R11 line stable while clock high", stableErr, 0);
    while (gotQ.size() > 0) @(posedge clk);
    check(expQ.size() == 0, "R8 all expected reads seen", expQ.size(), 0);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finishRun();
  end
endmodule